// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block produces a periodic tick interrupt. A base strobe, one pulse per period of a 32768 Hz reference, drives a free-running prescaler. A four-bit select value picks one of its bits, so the base rate is divided by a power of two from 1 to 32768. Each prescaled pulse decrements a down-counter. When the counter expires it reloads itself from a programmed count, raises a sticky status flag and drives the interrupt line. Software clears the flag by writing a one to it.

Software controls the block through a simple register port. A write takes one cycle and is qualified by a valid strobe. Reads are combinational and select a register by address. There are four word addresses: control at 0, count at 1, live counter at 2 and status at 3. Three control bits have fixed positions, because the start and stop logic decodes them: bit 0 is the master enable, bits [7:4] hold the divider select and bit 8 is the tick enable. The countdown starts only when a control write raises the tick enable while the master enable is set in the same written value. A count of zero blocks the start.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the control register, the count register, the live counter and the status register (address 3, bit 0) all read 0, and `tick_irq` is low.
- R2: A control write (address 0) whose bit 0 is 1 sets the divider select to bits [7:4] of the written value. While the timer runs, one tick period lasts count × 2^select base strobes. A new select takes effect without restarting the countdown.
- R3: A write of 0, 1 or 2 to the count register (address 1) is dropped and the previous count stays. A write of 3 or more is stored.
- R4: A control write with bit 0 = 1 and bit 8 = 1, made while the stored bit 8 is 0 and the stored count is nonzero, loads the count into the live counter (address 2) on that write and starts the countdown.
- R5: No countdown starts when bit 8 is already set in the stored control, when bit 0 of the written value is 0, or when the stored count is 0.
- R6: When the running counter expires, status bit 0 and `tick_irq` go high and stay high. The live counter reloads the programmed count in the same cycle and keeps counting.
- R7: A write to status (address 3) with bit 0 = 1 clears the flag and lowers `tick_irq`. A write with bit 0 = 0 changes nothing.
- R8: The countdown stops, and the live counter freezes, on a control write that clears bit 8 with bit 0 = 1. It also stops on a control write with bit 0 = 0 when the stored bit 0 was 1.
- R9: The live counter steps down by one on each prescaled pulse, and holds while `base_en` is low.
- R10: The control register reads back the last value written to it.
- R11: If an expiry and a status clear write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_en | input | 1 | One pulse per 32768 Hz reference period |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| tick_irq | output | 1 | Tick interrupt, high while the status flag is set |

## Verification
The in-RTL properties check, on every cycle:
- the count register never holds 1 or 2;
- the flag stays sticky until a one is written to it, and a clear lowers it;
- each expiry reloads the counter;
- the counter never runs at zero;
- the counter holds while stopped and steps by exactly one per prescaled pulse.

Only the directed scenarios can show the following:
- the decision to start or not, which depends on the stored control and the count;
- the period length for a given select value;
- that changing the select on a running timer causes no restart;
- that an expiry wins over a clear written in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int SEL_W     = 4;
    localparam int PRE_W     = (1 << SEL_W) - 1;
    localparam int MIN_COUNT = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_COUNT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_LIVE  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_FLAG  = ADDR_W'(3);

    localparam int BIT_MASTER = 0;
    localparam int SEL_LSB    = 4;
    localparam int BIT_TICK   = 8;

    typedef struct packed {
        logic             master;
        logic             tick;
        logic [SEL_W-1:0] sel;
    } ctrl_view_t;

    typedef struct packed {
        logic load;
        logic halt;
    } run_cmd_t;

    function automatic ctrl_view_t view_ctrl(input logic [DATA_W-1:0] v);
        ctrl_view_t c;
        c.master = v[BIT_MASTER];
        c.tick   = v[BIT_TICK];
        c.sel    = v[SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
        logic [PRE_W:0] m;
        m = ((PRE_W+1)'(1) << s) - (PRE_W+1)'(1);
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_timer_pkg::*;
#(
    parameter int P_SEL_W = SEL_W,
    parameter int P_PRE_W = PRE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               base_en,
    input  logic [P_SEL_W-1:0] sel,
    output logic               step
);

    logic [P_PRE_W-1:0] pre_q;
    logic [P_PRE_W-1:0] mask;

    assign mask = sel_mask(sel);
    // one pulse every 2^sel base strobes: low sel bits all ones just before wrap
    assign step = base_en && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (base_en)
            pre_q <= pre_q + 1'b1;
    end

    // R9: prescaler advances only on base strobes
    p_pre_adv_r9: assert property (@(posedge clk) disable iff (rst)
        base_en |=> pre_q == $past(pre_q) + 1'b1);
    p_pre_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !base_en |=> $stable(pre_q));

endmodule

// File: rtl/tick_downcount.sv
module tick_downcount
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  run_cmd_t         cmd,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] live,
    output logic             expire
);

    logic run_q;

    assign expire = run_q && step && (live <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            live  <= '0;
        end else if (cmd.load) begin
            run_q <= 1'b1;
            live  <= reload;
        end else if (cmd.halt) begin
            run_q <= 1'b0;
        end else if (expire) begin
            live <= reload;
        end else if (run_q && step) begin
            live <= live - 1'b1;
        end
    end

    // R4: a running counter never sits at zero
    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> live != '0);
    // R6: expiry reloads the programmed count
    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && !cmd.halt) |=> live == $past(reload));
    // R8: stopped counter is frozen
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cmd.load) |=> $stable(live));
    // R9: single decrement per prescaled pulse
    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && step && live > CNT_W'(1) && !cmd.load && !cmd.halt)
            |=> live == $past(live) - 1'b1);

endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
    import tick_timer_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SEL_W  = SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic                expire,
    output logic [P_DATA_W-1:0] ctrl_q,
    output logic [P_DATA_W-1:0] count_q,
    output logic [P_SEL_W-1:0]  sel_q,
    output logic                flag_q,
    output run_cmd_t            cmd
);

    logic       wr_ctrl, wr_count, wr_flag, clr_req;
    ctrl_view_t nv, ov;

    assign wr_ctrl  = wr_valid && (wr_addr == ADR_CTRL);
    assign wr_count = wr_valid && (wr_addr == ADR_COUNT);
    assign wr_flag  = wr_valid && (wr_addr == ADR_FLAG);
    assign clr_req  = wr_flag && wr_data[0];

    assign nv = view_ctrl(wr_data);
    assign ov = view_ctrl(ctrl_q);

    always_comb begin
        cmd.load = wr_ctrl && nv.master && nv.tick && !ov.tick && (count_q != '0);
        cmd.halt = wr_ctrl && ((!nv.master && ov.master) ||
                               (nv.master && !nv.tick && ov.tick));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            count_q <= '0;
            sel_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data;
                if (nv.master)
                    sel_q <= nv.sel;
            end
            if (wr_count && wr_data >= P_DATA_W'(MIN_COUNT))
                count_q <= wr_data;
            if (expire)
                flag_q <= 1'b1;
            else if (clr_req)
                flag_q <= 1'b0;
        end
    end

    // R3: count register never holds a refused value
    p_count_floor_r3: assert property (@(posedge clk) disable iff (rst)
        count_q == '0 || count_q >= P_DATA_W'(MIN_COUNT));
    // R6: expiry sets the flag
    p_expire_sets_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);
    // R6: flag is sticky without a clearing write
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);
    // R7: a one written to the flag clears it
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !expire) |=> !flag_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SEL_W  = SEL_W,
    parameter int P_PRE_W  = PRE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                base_en,
    input  logic                wr_valid,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] rd_addr,
    output logic [P_DATA_W-1:0] rd_data,
    output logic                tick_irq
);

    logic [P_DATA_W-1:0] ctrl_q, count_q, live;
    logic [P_SEL_W-1:0]  sel_q;
    logic                flag_q, step, expire;
    run_cmd_t            cmd;

    tick_prescaler #(.P_SEL_W(P_SEL_W), .P_PRE_W(P_PRE_W)) u_pre (
        .clk(clk), .rst(rst), .base_en(base_en), .sel(sel_q), .step(step)
    );

    tick_ctrl_regs #(.P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W), .P_SEL_W(P_SEL_W)) u_regs (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .expire(expire), .ctrl_q(ctrl_q), .count_q(count_q),
        .sel_q(sel_q), .flag_q(flag_q), .cmd(cmd)
    );

    tick_downcount #(.CNT_W(P_DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .cmd(cmd), .step(step), .reload(count_q),
        .live(live), .expire(expire)
    );

    assign tick_irq = flag_q;

    always_comb begin
        unique case (rd_addr)
            ADR_CTRL:  rd_data = ctrl_q;
            ADR_COUNT: rd_data = count_q;
            ADR_LIVE:  rd_data = live;
            ADR_FLAG:  rd_data = {{(P_DATA_W-1){1'b0}}, flag_q};
            default:   rd_data = '0;
        endcase
    end

    // R11: an expiry always leaves the interrupt raised, even with a clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        expire |=> tick_irq);

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        base_en;
    logic        wr_valid;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        tick_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst(rst), .base_en(base_en), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick_irq(tick_irq)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (!tick_irq && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(output int t);
        int n;
        wr(4'd3, 32'h1);
        wait_irq(1000, n);
        wr(4'd3, 32'h1);
        t = 1;
        while (!tick_irq && t < 1000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd1, v); chk("R1 count", v, 0);
        rd(4'd2, v); chk("R1 live", v, 0);
        rd(4'd3, v); chk("R1 flag", v, 0);
        chk("R1 irq", tick_irq, 0);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        wr(4'd0, 32'h101);
        cyc(8);
        rd(4'd2, v); chk("R5 zero count no start", v, 0);
        chk("R5 zero count irq", tick_irq, 0);
        wr(4'd0, 32'h000);
    endtask

    task automatic t_count_filter();
        logic [31:0] v;
        wr(4'd1, 32'd2); rd(4'd1, v); chk("R3 refuse 2", v, 0);
        wr(4'd1, 32'd7); rd(4'd1, v); chk("R3 accept 7", v, 7);
        wr(4'd1, 32'd1); rd(4'd1, v); chk("R3 refuse 1", v, 7);
        wr(4'd1, 32'd0); rd(4'd1, v); chk("R3 refuse 0", v, 7);
    endtask

    task automatic t_no_rise();
        logic [31:0] v;
        wr(4'd0, 32'h100);
        cyc(5);
        rd(4'd2, v); chk("R5 master off no start", v, 0);
        wr(4'd0, 32'h101);
        cyc(5);
        rd(4'd2, v); chk("R5 no rising edge", v, 0);
        chk("R5 irq quiet", tick_irq, 0);
        wr(4'd0, 32'h000);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(4'd1, 32'd5);
        wr(4'd0, 32'h101);
        rd(4'd2, v); chk("R4 load on start", v, 5);
        rd(4'd0, v); chk("R10 ctrl readback", v, 32'h101);
        cyc(1);
        rd(4'd2, v); chk("R9 decrement", v, 4);
        base_en = 1'b0;
        cyc(4);
        rd(4'd2, v); chk("R9 hold without base", v, 4);
        base_en = 1'b1;
        cyc(3);
        rd(4'd2, v); chk("R9 live at 1", v, 1);
        chk("R6 irq before expiry", tick_irq, 0);
        cyc(1);
        chk("R6 irq on expiry", tick_irq, 1);
        rd(4'd2, v); chk("R6 reload", v, 5);
        rd(4'd3, v); chk("R6 flag", v, 1);
        cyc(1);
        rd(4'd2, v); chk("R6 keeps running", v, 4);
        chk("R6 irq sticky", tick_irq, 1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(4'd3, 32'h0);
        chk("R7 write zero no effect", tick_irq, 1);
        wr(4'd3, 32'h1);
        chk("R7 clear irq", tick_irq, 0);
        rd(4'd3, v); chk("R7 flag cleared", v, 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(4'd0, 32'h001);
        rd(4'd2, v); chk("R8 tick clear freeze", v, 2);
        cyc(10);
        rd(4'd2, v); chk("R8 stays frozen", v, 2);
        chk("R8 no irq after stop", tick_irq, 0);
        wr(4'd0, 32'h101);
        rd(4'd2, v); chk("R4 restart", v, 5);
        cyc(1);
        wr(4'd0, 32'h100);
        rd(4'd2, v); chk("R8 master drop freeze", v, 4);
        cyc(10);
        rd(4'd2, v); chk("R8 master drop frozen", v, 4);
        chk("R8 master drop no irq", tick_irq, 0);
    endtask

    task automatic t_divider();
        int t;
        wr(4'd0, 32'h000);
        wr(4'd1, 32'd3);
        wr(4'd0, 32'h121);
        measure(t);
        chk("R2 period sel 2", t, 12);
        wr(4'd0, 32'h101);
        measure(t);
        chk("R2 period sel 0 without restart", t, 3);
    endtask

    task automatic t_same_cycle();
        int n;
        logic [31:0] v;
        wr(4'd3, 32'h1);
        wait_irq(100, n);
        cyc(2);
        wr(4'd3, 32'h1);
        chk("R11 set wins over clear", tick_irq, 1);
        rd(4'd2, v); chk("R11 reload at collision", v, 3);
        wr(4'd3, 32'h1);
        chk("R7 clear after collision", tick_irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; base_en = 1'b1; wr_valid = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_zero_count();
        t_count_filter();
        t_no_rise();
        t_start();
        t_w1c();
        t_stop();
        t_divider();
        t_same_cycle();
        summary();
        $finish;
    end

endmodule